// File: doc/BRIEF.md
# Quadrature Encoder Position Counter with Selectable Clear

This block keeps a 16-bit position count from a two-phase quadrature encoder, stepping up or down by one on every valid phase transition. Alongside the two phase inputs it watches an index (reference mark) input. A small 8-bit control register chooses how the count is returned to zero.

In index-edge mode, a chosen edge of the index input (rising, falling, either, or none) clears the count and raises a one-clock clear interrupt. In level-match mode, the count is held at zero for as long as the index, phase B and phase A inputs all sit at levels programmed in the register. This mode raises no interrupt.

Clearing is only permitted when the external count-direction field has its upper bit set (values 10 or 11). Every encoder input first passes through a two-flop synchronizer.

Top module: `qcu_clear_unit`

## Requirements
- R1: After reset the control register reads 00H, the count is 0000H and the clear interrupt is low.
- R2: A byte write (`wr_en`) loads `wr_data` into the register. A bit write (`wr_bit_en`) loads `wr_data[0]` into the bit indexed by `wr_bit_sel`. When both are requested in one cycle, the byte write wins. `rd_data` always returns the register.
- R3: Register layout: bit 7 is the clear mode (0 edge, 1 level match). Bit 6 is the index level, bit 5 the phase-B level and bit 4 the phase-A level. Bits 3:2 are the edge select. Bits 1:0 are stored with no effect on counting or clearing.
- R4: Taking {A,B}, the sequence 00→10→11→01→00 counts up by one per step and the reverse counts down. A change of both phases at once leaves the count unchanged. The count wraps modulo 65536.
- R5: In edge mode, edge select 01 clears on a rising index edge, 10 on a falling edge, 11 on either, and 00 never. The three level bits have no effect in this mode.
- R6: The clear interrupt is a one-clock pulse, high in the same cycle that the count first reads 0000H after an edge clear.
- R7: In level-match mode, the count reads 0000H for as long as all three synchronized pins equal their level bits. The edge select has no effect, and the interrupt stays low.
- R8: A level bit of 0 requires the pin to be low, and 1 requires it to be high.
- R9: When `count_dir[1]` is 0, no clear happens and no interrupt is raised in either mode.
- R10: When a clear and a count step fall in the same cycle, the count becomes 0000H.
- R11: A change on any encoder input shows at the outputs after exactly three rising clock edges: two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_sel | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Write data (bit 0 for bit writes) |
| rd_data | output | 8 | Control register contents |
| count_dir | input | 2 | Count-direction field; clear enabled when bit 1 is set |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| count | output | 16 | Position count |
| clr_irq | output | 1 | One-clock clear interrupt |

## Verification
A wrong synchronized or previous-sample state shows up as a count step in the wrong direction, a missed step, or a clear on the wrong index edge. Any of these appears at `count` on the third clock edge after the input change. A decode fault in the clear logic shows as a count that is not held at zero while the pins match, or as an interrupt raised in level mode. Both show one edge after the synchronized condition. Because the count is never rebuilt from the pins, a single missed step stays visible until the next clear.

// File: rtl/qcu_pkg.sv
package qcu_pkg;
  localparam int unsigned CTL_W      = 8;
  localparam int unsigned BIT_MODE   = 7;
  localparam int unsigned BIT_LV_IDX = 6;
  localparam int unsigned BIT_LV_B   = 5;
  localparam int unsigned BIT_LV_A   = 4;
  localparam int unsigned BIT_ES_HI  = 3;
  localparam int unsigned BIT_ES_LO  = 2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Position of a phase code {A,B} on the forward cycle 00,10,11,01
  function automatic logic [1:0] quad_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   quad_pos = 2'd0;
      2'b10:   quad_pos = 2'd1;
      2'b11:   quad_pos = 2'd2;
      default: quad_pos = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/qcu_sync.sv
module qcu_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qcu_ctrl_reg.sv
module qcu_ctrl_reg
  import qcu_pkg::*;
#(
  parameter int unsigned W = CTL_W,
  localparam int unsigned SEL_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit_en,
  input  logic [SEL_W-1:0] wr_bit_sel,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     ctrl_q
);
  logic [W-1:0] ctrl_d;
  logic         ctrl_en;

  assign ctrl_en = wr_en | wr_bit_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = wr_data;
    end else if (wr_bit_en) begin
      ctrl_d[wr_bit_sel] = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/qcu_quad_dec.sv
module qcu_quad_dec
  import qcu_pkg::*;
(
  input  logic [1:0] ab_cur,
  input  logic [1:0] ab_prev,
  output logic       step_up,
  output logic       step_dn
);
  logic [1:0] delta;

  always_comb begin
    delta   = quad_pos(ab_cur) - quad_pos(ab_prev);
    step_up = (delta == 2'd1);
    step_dn = (delta == 2'd3);
  end
endmodule

// File: rtl/qcu_clear_logic.sv
module qcu_clear_logic
  import qcu_pkg::*;
(
  input  logic [CTL_W-1:0] ctrl,
  input  logic [1:0]       count_dir,
  input  logic             idx_cur,
  input  logic             idx_prev,
  input  logic             a_cur,
  input  logic             b_cur,
  output logic             clr_req,
  output logic             irq_req
);
  edge_sel_e esel;
  logic      rise, fall, edge_hit, level_hit, allow;

  always_comb begin
    esel  = edge_sel_e'(ctrl[BIT_ES_HI:BIT_ES_LO]);
    rise  = idx_cur & ~idx_prev;
    fall  = ~idx_cur & idx_prev;
    allow = count_dir[1];

    case (esel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase

    level_hit = (idx_cur == ctrl[BIT_LV_IDX]) &&
                (b_cur   == ctrl[BIT_LV_B])   &&
                (a_cur   == ctrl[BIT_LV_A]);

    if (ctrl[BIT_MODE]) begin
      clr_req = allow & level_hit;
      irq_req = 1'b0;
    end else begin
      clr_req = allow & edge_hit;
      irq_req = allow & edge_hit;
    end
  end
endmodule

// File: rtl/qcu_clear_unit.sv
module qcu_clear_unit
  import qcu_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit_en,
  input  logic [2:0]       wr_bit_sel,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rd_data,
  input  logic [1:0]       count_dir,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  output logic [CNT_W-1:0] count,
  output logic             clr_irq
);
  localparam int unsigned NPIN = 3;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  logic [CTL_W-1:0] ctrl_q;
  qcu_ctrl_reg #(.W(CTL_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_bit_en  (wr_bit_en),
    .wr_bit_sel (wr_bit_sel),
    .wr_data    (wr_data),
    .ctrl_q     (ctrl_q)
  );
  assign rd_data = ctrl_q;

  logic [NPIN-1:0] pin_s;
  qcu_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({enc_idx, enc_b, enc_a}),
    .q     (pin_s)
  );

  logic idx_s, b_s, a_s;
  assign {idx_s, b_s, a_s} = pin_s;

  logic [NPIN-1:0] pin_p;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pin_p <= '0;
    else             pin_p <= pin_s;
  end

  logic step_up, step_dn;
  qcu_quad_dec u_dec (
    .ab_cur  ({a_s, b_s}),
    .ab_prev ({pin_p[0], pin_p[1]}),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  logic clr_req, irq_req;
  qcu_clear_logic u_clr (
    .ctrl      (ctrl_q),
    .count_dir (count_dir),
    .idx_cur   (idx_s),
    .idx_prev  (pin_p[2]),
    .a_cur     (a_s),
    .b_cur     (b_s),
    .clr_req   (clr_req),
    .irq_req   (irq_req)
  );

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_req | step_up | step_dn;
    if (clr_req)      cnt_d = '0;
    else if (step_up) cnt_d = count + 1'b1;
    else if (step_dn) cnt_d = count - 1'b1;
    else              cnt_d = count;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      count   <= '0;
      clr_irq <= 1'b0;
    end else begin
      if (cnt_en) count <= cnt_d;
      clr_irq <= irq_req;
    end
  end
endmodule

// File: rtl/qcu_checker.sv
module qcu_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctrl,
  input logic [1:0]       count_dir,
  input logic             idx_s,
  input logic             a_s,
  input logic             b_s,
  input logic [CNT_W-1:0] count,
  input logic             clr_irq
);
  a_r7_level_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && count_dir[1] && idx_s == ctrl[6] && b_s == ctrl[5] && a_s == ctrl[4])
      |=> (count == '0));

  a_r7_no_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq |-> !$past(ctrl[7]));

  a_r6_irq_with_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq |-> (count == '0));

  a_r9_irq_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq |-> $past(count_dir[1]));

  a_r5_none_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq |-> ($past(ctrl[3:2]) != 2'b00));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) ||
    (count == $past(count) - 1'b1) || (count == '0));
endmodule

bind qcu_clear_unit qcu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ctrl      (ctrl_q),
  .count_dir (count_dir),
  .idx_s     (idx_s),
  .a_s       (a_s),
  .b_s       (b_s),
  .count     (count),
  .clr_irq   (clr_irq)
);

// File: tb/qcu_clear_unit_tb.sv
module qcu_clear_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        wr_en, wr_bit_en;
  logic [2:0]  wr_bit_sel;
  logic [7:0]  wr_data, rd_data;
  logic [1:0]  count_dir;
  logic        enc_a, enc_b, enc_idx;
  logic [15:0] count;
  logic        clr_irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] m_cnt;

  qcu_clear_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit_en(wr_bit_en),
    .wr_bit_sel(wr_bit_sel), .wr_data(wr_data), .rd_data(rd_data),
    .count_dir(count_dir), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .count(count), .clr_irq(clr_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [1:0] up_next(input logic [1:0] ab);
    case (ab)
      2'b00: up_next = 2'b10;
      2'b10: up_next = 2'b11;
      2'b11: up_next = 2'b01;
      default: up_next = 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] dn_next(input logic [1:0] ab);
    case (ab)
      2'b00: dn_next = 2'b01;
      2'b01: dn_next = 2'b11;
      2'b11: dn_next = 2'b10;
      default: dn_next = 2'b00;
    endcase
  endfunction

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic pump(input int n, input bit up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {enc_a, enc_b} = up ? up_next({enc_a, enc_b}) : dn_next({enc_a, enc_b});
      m_cnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
    end
    settle();
  endtask

  // Changes index; expects a clear (with or without interrupt) on edge 3
  task automatic idx_clear(input string req, input logic v, input logic exp_irq);
    @(negedge clk); enc_idx = v;
    @(negedge clk);
    @(negedge clk);
    check({req, " R11 not yet cleared"}, count, m_cnt);
    @(negedge clk);
    check({req, " cleared"}, count, 16'h0000);
    check({req, " R6 irq"}, {15'd0, clr_irq}, {15'd0, exp_irq});
    @(negedge clk);
    check({req, " R6 irq one cycle"}, {15'd0, clr_irq}, 16'd0);
    m_cnt = 16'h0;
  endtask

  // Changes index; expects no clear and no interrupt
  task automatic idx_keep(input string req, input logic v);
    @(negedge clk); enc_idx = v;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check({req, " no irq"}, {15'd0, clr_irq}, 16'd0);
    end
    check({req, " count kept"}, count, m_cnt);
  endtask

  task automatic t_reset();
    check("R1 ctrl", {8'd0, rd_data}, 16'h0000);
    check("R1 count", count, 16'h0000);
    check("R1 irq", {15'd0, clr_irq}, 16'd0);
  endtask

  task automatic t_reg();
    wr_byte(8'hA5);
    check("R2 byte write", {8'd0, rd_data}, 16'h00A5);
    @(negedge clk); wr_bit_en = 1'b1; wr_bit_sel = 3'd6; wr_data = 8'h01;
    @(negedge clk); wr_bit_en = 1'b0;
    check("R2 bit set", {8'd0, rd_data}, 16'h00E5);
    @(negedge clk); wr_bit_en = 1'b1; wr_bit_sel = 3'd0; wr_data = 8'h00;
    @(negedge clk); wr_bit_en = 1'b0;
    check("R2 bit clear", {8'd0, rd_data}, 16'h00E4);
    @(negedge clk); wr_en = 1'b1; wr_bit_en = 1'b1; wr_bit_sel = 3'd7; wr_data = 8'h12;
    @(negedge clk); wr_en = 1'b0; wr_bit_en = 1'b0;
    check("R2 byte wins", {8'd0, rd_data}, 16'h0012);
    wr_byte(8'h00);
  endtask

  task automatic t_count();
    pump(1, 1'b0);
    check("R4 wrap down", count, 16'hFFFF);
    pump(6, 1'b1);
    check("R4 count up", count, 16'h0005);
    pump(2, 1'b0);
    check("R4 count down", count, 16'h0003);
    @(negedge clk); {enc_a, enc_b} = ~{enc_a, enc_b};
    settle();
    check("R4 double change held", count, m_cnt);
    wr_byte(8'h03);
    pump(1, 1'b1);
    check("R3 low field no effect", count, m_cnt);
    wr_byte(8'h00);
  endtask

  task automatic t_edges();
    wr_byte(8'h04);
    pump(2, 1'b1);
    idx_clear("R5 rising", 1'b1, 1'b1);
    pump(2, 1'b1);
    idx_keep("R5 rising ignores fall", 1'b0);
    wr_byte(8'h08);
    idx_keep("R5 falling ignores rise", 1'b1);
    idx_clear("R5 falling", 1'b0, 1'b1);
    wr_byte(8'h0C);
    pump(3, 1'b1);
    idx_clear("R5 both rise", 1'b1, 1'b1);
    pump(1, 1'b1);
    idx_clear("R5 both fall", 1'b0, 1'b1);
    wr_byte(8'h70);
    pump(2, 1'b1);
    idx_keep("R5 none with levels", 1'b1);
    idx_keep("R5 none fall", 1'b0);
  endtask

  task automatic t_level();
    wr_byte(8'h00);
    while ({enc_a, enc_b} != 2'b10) pump(1, 1'b1);
    wr_byte(8'hDC);
    settle();
    check("R7 idx mismatch keeps count", count, m_cnt);
    idx_clear("R7 level match", 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R7 held zero", count, 16'h0000);
      check("R7 no irq", {15'd0, clr_irq}, 16'd0);
    end
    pump(1, 1'b1);
    check("R8 B high mismatches", count, 16'h0001);
    wr_byte(8'h80);
    @(negedge clk); enc_idx = 1'b0;
    pump(1, 1'b1);
    check("R8 A low B high mismatches", count, 16'h0002);
    pump(1, 1'b1);
    check("R8 all low clears", count, 16'h0000);
    check("R7 no irq at clear", {15'd0, clr_irq}, 16'd0);
    m_cnt = 16'h0;
    wr_byte(8'h00);
  endtask

  task automatic t_gate();
    count_dir = 2'b01;
    wr_byte(8'h04);
    pump(2, 1'b1);
    idx_keep("R9 dir 01 blocks edge", 1'b1);
    wr_byte(8'h80);
    pump(1, 1'b1);
    pump(1, 1'b1);
    check("R9 dir 01 blocks level", count, m_cnt);
    idx_keep("R9 dir 01 blocks level idx", 1'b0);
    wr_byte(8'h04);
    count_dir = 2'b11;
    pump(1, 1'b1);
    idx_clear("R9 dir 11 allows", 1'b1, 1'b1);
    count_dir = 2'b10;
  endtask

  task automatic t_prio();
    wr_byte(8'h0C);
    pump(2, 1'b1);
    @(negedge clk);
    enc_idx = 1'b0;
    {enc_a, enc_b} = up_next({enc_a, enc_b});
    repeat (3) @(negedge clk);
    check("R10 clear beats count", count, 16'h0000);
    check("R10 irq", {15'd0, clr_irq}, 16'd1);
    m_cnt = 16'h0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_bit_en = 1'b0; wr_bit_sel = 3'd0;
    wr_data = 8'h00; count_dir = 2'b10;
    enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b0; m_cnt = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reg();
    t_count();
    t_edges();
    t_level();
    t_gate();
    t_prio();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule